// File: doc/BRIEF.md
# Serial Command and Display-Data Receiver

This block is the host-facing serial slave of a display controller. A microcontroller selects it by pulling an active-low enable low and then clocks in bytes most significant bit first. Each received byte is handed to the rest of the chip as a one-cycle strobe with the byte and a flag. The flag tells command bytes (flag 0) from display-data bytes (flag 1). Several bytes may follow one another while the enable stays low. Raising the enable clears the receiver and throws away any partial byte.

A static mode strap selects one of two framings. In three-wire mode every transmission is nine serial clocks long, and the first bit carries the flag. In four-wire mode every transmission is eight clocks long, and the flag is read from a sideband pin. When the receiver sees a command byte equal to the read-status code, it turns the line around. It then shifts one status byte out on the serial data output and ignores the serial clock until the enable goes high again.

The serial inputs are sampled by a fast system clock through a synchronizer. All state is cleared by a synchronous active-high reset.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, rx_valid, rx_byte, rx_is_data, sdout and sdout_en are all 0.
- R2: With four_wire=1, eight rising sclk edges under sce_n=0 deliver one byte, with the first bit as bit 7. rx_is_data equals dc_in as sampled at the eighth rising edge.
- R3: With four_wire=0, nine rising sclk edges deliver one byte. The first bit is the flag (1 = data, 0 = command), and the next eight bits form the byte from bit 7 down to bit 0.
- R4: Bytes sent back to back under one low period of sce_n are each delivered, in order.
- R5: While sce_n is high, sclk has no effect. Raising sce_n discards a partial byte, and the next frame starts from its first bit.
- R6: rx_valid is a single-cycle pulse. It is first seen high SYNC_STAGES+1 clk cycles after the rising sclk edge of the last bit.
- R7: A command byte (flag 0) equal to RD_CMD (default 0xD9) starts a read. The status_in value captured at that moment is driven on sdout, bit 7 first. sdout changes only after falling sclk edges, and sdout_en is 1 for the eight read bits.
- R8: After the eighth read bit, sdout_en returns to 0. No byte is delivered until sce_n has gone high and low again.
- R9: Asserting rst in the middle of a frame aborts it. A complete frame sent afterwards is delivered unchanged.
- R10: A data byte (flag 1) equal to RD_CMD is delivered as data and does not start a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| four_wire | input | 1 | Mode strap: 1 = 8-bit frames with sideband flag, 0 = 9-bit frames with in-band flag |
| sce_n | input | 1 | Active-low chip enable |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host |
| dc_in | input | 1 | Sideband data/command flag, used in four-wire mode |
| status_in | input | DATA_W | Status byte returned by a read |
| sdout | output | 1 | Serial data to the host |
| sdout_en | output | 1 | High while sdout carries read bits |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | DATA_W | Received byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
Every serial pin passes through SYNC_STAGES flops, and edge detection adds one more register. A received byte therefore shows on rx_valid SYNC_STAGES+1 clk cycles after the last rising sclk edge. A read bit shows on sdout the same number of cycles after a falling edge. The bench changes its inputs on falling clk edges and holds each sclk level for four clk cycles. It reads results at the end of that hold, after the result has settled and before the next edge. One dedicated test counts clk cycles from the final rising sclk edge and checks that the strobe arrives in exactly the third cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [1:0] {
    ST_RECV = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } link_state_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sce_n,
  input  logic sclk,
  input  logic sdin,
  input  logic dc_in,
  output logic sel_off,
  output logic clk_rise,
  output logic clk_fall,
  output logic din_s,
  output logic dc_s
);
  // bit order within a stage: {dc, sdin, sclk, sce_n}
  localparam logic [3:0] IDLE_V = 4'b0001;

  logic [3:0] stg [STAGES];
  logic       sclk_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE_V;
        else     stg[0] <= {dc_in, sdin, sclk, sce_n};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_V;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= stg[STAGES-1][1];
  end

  assign sel_off  = stg[STAGES-1][0];
  assign clk_rise = stg[STAGES-1][1] & ~sclk_d;
  assign clk_fall = ~stg[STAGES-1][1] & sclk_d;
  assign din_s    = stg[STAGES-1][2];
  assign dc_s     = stg[STAGES-1][3];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  RD_CMD = 8'hD9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              four_wire,
  input  logic              sel_off,
  input  logic              clk_rise,
  input  logic              din_s,
  input  logic              dc_s,
  input  logic              rx_enable,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_data,
  output logic              rd_arm
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_4W = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_3W = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              flag_q;
  logic [CNT_W-1:0]  last_idx;
  logic [DATA_W-1:0] next_byte;
  logic              next_flag;

  always_comb begin
    last_idx  = four_wire ? LAST_4W : LAST_3W;
    next_byte = {shreg[DATA_W-2:0], din_s};
    next_flag = four_wire ? dc_s : flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      flag_q     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
      rd_arm     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rd_arm   <= 1'b0;
      if (sel_off || !rx_enable) begin
        bit_cnt <= '0;
      end else if (clk_rise) begin
        if (!four_wire && bit_cnt == '0) flag_q <= din_s;
        else                             shreg  <= next_byte;
        if (bit_cnt == last_idx) begin
          bit_cnt    <= '0;
          rx_valid   <= 1'b1;
          rx_byte    <= next_byte;
          rx_is_data <= next_flag;
          rd_arm     <= !next_flag && (next_byte == DATA_W'(RD_CMD));
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R6
  property rx_pulse_p;
    @(posedge clk) disable iff (rst) rx_valid |=> !rx_valid;
  endproperty
  rx_single_pulse_chk: assert property (rx_pulse_p);

  // R5
  property sel_quiet_p;
    @(posedge clk) disable iff (rst) sel_off |=> !rx_valid;
  endproperty
  sel_off_quiet_chk: assert property (sel_quiet_p);

  // R3
  property cnt_bound_p;
    @(posedge clk) disable iff (rst) bit_cnt <= LAST_3W;
  endproperty
  bit_cnt_bound_chk: assert property (cnt_bound_p);
endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_off,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              rd_arm,
  input  logic [DATA_W-1:0] status_in,
  output logic              sdout,
  output logic              sdout_en,
  output logic              rx_enable
);
  localparam int RC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [RC_W-1:0] LAST_RISE = RC_W'(DATA_W - 1);

  link_state_t       st;
  logic [DATA_W-1:0] tx_sr;
  logic [RC_W-1:0]   rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RECV;
      tx_sr    <= '0;
      rise_cnt <= '0;
      sdout    <= 1'b0;
    end else if (sel_off) begin
      st <= ST_RECV;
    end else begin
      case (st)
        ST_RECV: if (rd_arm) begin
          st       <= ST_SEND;
          tx_sr    <= status_in;
          rise_cnt <= '0;
        end
        ST_SEND: begin
          if (clk_fall) begin
            sdout <= tx_sr[DATA_W-1];
            tx_sr <= tx_sr << 1;
          end
          if (clk_rise) begin
            if (rise_cnt == LAST_RISE) st <= ST_HOLD;
            else                       rise_cnt <= rise_cnt + 1'b1;
          end
        end
        default: st <= ST_HOLD;
      endcase
    end
  end

  assign sdout_en  = (st == ST_SEND);
  assign rx_enable = (st == ST_RECV);

  // R7
  property sdout_hold_p;
    @(posedge clk) disable iff (rst) !(clk_fall && st == ST_SEND) |=> $stable(sdout);
  endproperty
  sdout_on_fall_chk: assert property (sdout_hold_p);
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RD_CMD      = 8'hD9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              four_wire,
  input  logic              sce_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              dc_in,
  input  logic [DATA_W-1:0] status_in,
  output logic              sdout,
  output logic              sdout_en,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_data
);
  logic sel_off, clk_rise, clk_fall, din_s, dc_s;
  logic rx_enable, rd_arm;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sce_n(sce_n), .sclk(sclk), .sdin(sdin), .dc_in(dc_in),
    .sel_off(sel_off), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .din_s(din_s), .dc_s(dc_s)
  );

  spi_frame_rx #(.DATA_W(DATA_W), .RD_CMD(RD_CMD)) u_frame (
    .clk(clk), .rst(rst), .four_wire(four_wire), .sel_off(sel_off),
    .clk_rise(clk_rise), .din_s(din_s), .dc_s(dc_s), .rx_enable(rx_enable),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_data(rx_is_data),
    .rd_arm(rd_arm)
  );

  spi_status_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .sel_off(sel_off), .clk_rise(clk_rise),
    .clk_fall(clk_fall), .rd_arm(rd_arm), .status_in(status_in),
    .sdout(sdout), .sdout_en(sdout_en), .rx_enable(rx_enable)
  );

  // R8
  property send_blocks_rx_p;
    @(posedge clk) disable iff (rst) sdout_en |=> !rx_valid;
  endproperty
  send_blocks_rx_chk: assert property (send_blocks_rx_p);
endmodule

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;
  localparam logic [7:0] RD = 8'hD9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic four_wire = 1'b1;
  logic sce_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic dc_in = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic sdout, sdout_en, rx_valid, rx_is_data;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  int cap_cnt = 0;
  logic [7:0] cap_byte = 8'h00;
  logic cap_flag = 1'b0;
  logic prev_valid = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst(rst), .four_wire(four_wire), .sce_n(sce_n), .sclk(sclk),
    .sdin(sdin), .dc_in(dc_in), .status_in(status_in), .sdout(sdout),
    .sdout_en(sdout_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_data(rx_is_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_cnt++;
      cap_byte = rx_byte;
      cap_flag = rx_is_data;
      if (prev_valid) check(1'b0, "R6 pulse width", 2, 1);
    end
    prev_valid = rx_valid;
  end

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b);
    sdin = b;
    wait_n(4);
    sclk = 1'b1;
    wait_n(4);
    sclk = 1'b0;
  endtask

  task automatic send_frame(input logic flag, input logic [7:0] b);
    dc_in = flag;
    if (!four_wire) spi_bit(flag);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    wait_n(4);
  endtask

  task automatic expect_rx(input string req, input int base, input logic [7:0] eb, input logic ef);
    check(cap_cnt == base + 1, req, cap_cnt, base + 1);
    check(cap_byte == eb && cap_flag == ef, req, {cap_flag, cap_byte}, {ef, eb});
  endtask

  initial begin
    int base;
    int seen;
    logic [7:0] got;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    check(!rx_valid && rx_byte == 0 && !rx_is_data && !sdout && !sdout_en,
          "R1 reset", {rx_valid, rx_is_data, sdout, sdout_en, rx_byte}, 0);

    // R2 R4 four-wire sweep, back to back under one enable
    four_wire = 1'b1;
    sce_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      if (v != RD) begin
        base = cap_cnt;
        send_frame(v[0] ^ v[3], 8'(v));
        expect_rx("R2 R4 four-wire byte", base, 8'(v), v[0] ^ v[3]);
      end
    end
    sce_n = 1'b1;
    wait_n(6);

    // R3 three-wire sweep, in-band flag
    four_wire = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic f;
      f = (v == RD) ? 1'b1 : (v[7] ^ v[1]);
      sce_n = 1'b0;
      base = cap_cnt;
      dc_in = ~f;
      sdin = f; wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0;
      for (int i = 7; i >= 0; i--) spi_bit(v[i]);
      wait_n(4);
      expect_rx("R3 three-wire byte", base, 8'(v), f);
      sce_n = 1'b1;
      wait_n(4);
    end

    // R6 latency of the strobe
    four_wire = 1'b1;
    sce_n = 1'b0;
    dc_in = 1'b1;
    for (int i = 7; i >= 1; i--) spi_bit(1'b0);
    sdin = 1'b1;
    wait_n(4);
    sclk = 1'b1;
    seen = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (rx_valid && seen == 0) seen = k;
    end
    sclk = 1'b0;
    check(seen == 3, "R6 strobe latency", seen, 3);
    check(cap_byte == 8'h01, "R6 latency byte", cap_byte, 8'h01);
    wait_n(4);

    // R5 partial byte discarded, sclk ignored while enable high
    for (int i = 0; i < 5; i++) spi_bit(1'b1);
    sce_n = 1'b1;
    wait_n(6);
    base = cap_cnt;
    for (int i = 0; i < 12; i++) spi_bit(1'b1);
    wait_n(4);
    check(cap_cnt == base, "R5 sclk ignored while high", cap_cnt, base);
    sce_n = 1'b0;
    wait_n(4);
    send_frame(1'b0, 8'h3C);
    expect_rx("R5 restart after partial", base, 8'h3C, 1'b0);

    // R9 reset aborts a frame
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(4);
    base = cap_cnt;
    send_frame(1'b1, 8'h81);
    expect_rx("R9 frame after reset", base, 8'h81, 1'b1);

    // R10 data byte equal to read code does not start a read
    base = cap_cnt;
    send_frame(1'b1, RD);
    expect_rx("R10 data read code", base, RD, 1'b1);
    check(!sdout_en, "R10 no turnaround", sdout_en, 0);
    base = cap_cnt;
    send_frame(1'b1, 8'h55);
    expect_rx("R10 next byte", base, 8'h55, 1'b1);

    // R7 read status, four-wire
    status_in = 8'hA5;
    base = cap_cnt;
    send_frame(1'b0, RD);
    expect_rx("R7 read command", base, RD, 1'b0);
    status_in = 8'h00;
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      check(sdout_en, "R7 sdout_en during read", sdout_en, 1);
      got[i] = sdout;
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
    check(got == 8'hA5, "R7 status byte", got, 8'hA5);

    // R8 locked until enable cycles
    check(!sdout_en, "R8 sdout_en released", sdout_en, 0);
    base = cap_cnt;
    send_frame(1'b1, 8'h12);
    check(cap_cnt == base, "R8 bytes ignored after read", cap_cnt, base);
    sce_n = 1'b1;
    wait_n(6);
    sce_n = 1'b0;
    wait_n(4);
    send_frame(1'b1, 8'h34);
    expect_rx("R8 accepted after enable cycle", base, 8'h34, 1'b1);
    sce_n = 1'b1;
    wait_n(6);

    // R7 read status, three-wire, from a different pattern
    four_wire = 1'b0;
    sce_n = 1'b0;
    status_in = 8'h3E;
    base = cap_cnt;
    send_frame(1'b0, RD);
    expect_rx("R7 three-wire read command", base, RD, 1'b0);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      got[i] = sdout;
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
    check(got == 8'h3E, "R7 three-wire status byte", got, 8'h3E);
    check(!sdout_en, "R8 three-wire release", sdout_en, 0);
    sce_n = 1'b1;
    wait_n(6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule